// File: doc/BRIEF.md
# Seven-State Permuted Counter

This block is a synchronous 3-bit counter that runs through a fixed cycle of seven codes in a non-binary order: 0, 3, 2, 1, 5, 4, 7, and then back to 0. Code 6 is never part of the cycle. If the register ever holds code 6, the next enabled clock edge sends it to 0, so the counter rejoins the cycle at a known point.

All three flip-flops share one clock edge. A count enable moves the counter one step per rising edge. A synchronous reset returns the counter to 0. A test-only preload port writes any code, including the unused one, straight into the register, so that the recovery path can be exercised.

Top module: `perm7_counter`

## Requirements
- R1: With `step_en` high and `clear` and `force_en` low, each rising edge advances `count` along the order 0→3, 3→2, 2→1, 1→5, 5→4, 4→7.
- R2: From 7, an enabled edge wraps `count` to 0, so the seven-code cycle repeats without end.
- R3: With `step_en`, `clear` and `force_en` all low, `count` keeps its value across the edge. This applies to code 6 as well.
- R4: When `count` is 6 and an enabled edge occurs, `count` becomes 0 on that edge, and it never becomes 6 through stepping.
- R5: With `clear` high, the next rising edge sets `count` to 0, whatever the values of `step_en` and `force_en`.
- R6: With `force_en` high and `clear` low, the next rising edge loads `force_val` into `count`, whatever the value of `step_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all state bits |
| clear | input | 1 | Synchronous active-high reset to code 0 |
| step_en | input | 1 | Advance one step on this edge when high |
| force_en | input | 1 | Test-only: load `force_val` on this edge |
| force_val | input | 3 | Test-only code to load |
| count | output | 3 | Current counter code |

## Verification
Each input pattern takes effect on the first rising edge that sees it, and `count` shows the result just after that edge. No register stands between the inputs and the output except the state register itself. The bench therefore changes inputs on the falling edge, waits for one rising edge, and samples `count` one nanosecond later. It checks every transition over two full periods, the hold case, the wrap, and recovery from a preloaded code 6.

// File: rtl/perm7_counter.sv
module perm7_counter #(
  parameter logic [2:0] RECOVER_CODE = 3'd0
) (
  input  logic       clk,
  input  logic       clear,
  input  logic       step_en,
  input  logic       force_en,
  input  logic [2:0] force_val,
  output logic [2:0] count
);

  logic [2:0] succ;

  always_comb begin
    unique case (count)
      3'd0:    succ = 3'd3;
      3'd3:    succ = 3'd2;
      3'd2:    succ = 3'd1;
      3'd1:    succ = 3'd5;
      3'd5:    succ = 3'd4;
      3'd4:    succ = 3'd7;
      3'd7:    succ = 3'd0;
      default: succ = RECOVER_CODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clear)         count <= 3'd0;
    else if (force_en) count <= force_val;
    else if (step_en)  count <= succ;
  end

endmodule

module perm7_counter_chk (
  input logic       clk,
  input logic       clear,
  input logic       step_en,
  input logic       force_en,
  input logic [2:0] force_val,
  input logic [2:0] count
);

  AST_STEP_ZERO: assert property (@(posedge clk) disable iff (clear)
    (!force_en && step_en && count == 3'd0) |=> count == 3'd3); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (clear)
    (!force_en && step_en && count == 3'd1) |=> count == 3'd5); // R1
  AST_WRAP: assert property (@(posedge clk) disable iff (clear)
    (!force_en && step_en && count == 3'd7) |=> count == 3'd0); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (clear)
    (!force_en && !step_en) |=> $stable(count)); // R3
  AST_RECOVER: assert property (@(posedge clk) disable iff (clear)
    (!force_en && step_en && count == 3'd6) |=> count == 3'd0); // R4
  AST_NO_SIX: assert property (@(posedge clk) disable iff (clear)
    (!force_en && step_en) |=> count != 3'd6); // R4
  AST_PRELOAD: assert property (@(posedge clk) disable iff (clear)
    force_en |=> count == $past(force_val)); // R6

endmodule

bind perm7_counter perm7_counter_chk u_chk (
  .clk(clk), .clear(clear), .step_en(step_en),
  .force_en(force_en), .force_val(force_val), .count(count)
);

// File: tb/test_perm7_counter.sv
module test_perm7_counter;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       step_en = 1'b0;
  logic       force_en = 1'b0;
  logic [2:0] force_val = 3'd0;
  logic [2:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perm7_counter i_perm7_counter (
    .clk(clk), .clear(clear), .step_en(step_en),
    .force_en(force_en), .force_val(force_val), .count(count)
  );

  // {step_en, expected count after edge}, starting from 0
  localparam logic [3:0] VEC [16] = '{
    4'b1_011, 4'b1_010, 4'b1_001, 4'b1_101, 4'b1_100, 4'b1_111, 4'b1_000,
    4'b1_011, 4'b1_010, 4'b1_001, 4'b1_101, 4'b1_100, 4'b1_111, 4'b1_000,
    4'b0_000, 4'b1_011
  };

  task automatic apply(input logic c, input logic e, input logic f,
                       input logic [2:0] v);
    @(negedge clk);
    clear = c; step_en = e; force_en = f; force_val = v;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  initial begin
    apply(1'b1, 1'b0, 1'b0, 3'd0);
    check("R5", 3'd0);

    foreach (VEC[i]) begin
      apply(1'b0, VEC[i][3], 1'b0, 3'd0);
      if (VEC[i][2:0] == 3'd0 && VEC[i][3]) check("R2", VEC[i][2:0]);
      else if (!VEC[i][3])                  check("R3", VEC[i][2:0]);
      else                                  check("R1", VEC[i][2:0]);
    end

    apply(1'b0, 1'b1, 1'b0, 3'd0);
    check("R1", 3'd2);
    apply(1'b1, 1'b1, 1'b0, 3'd0);
    check("R5", 3'd0);
    apply(1'b1, 1'b1, 1'b1, 3'd5);
    check("R5", 3'd0);

    apply(1'b0, 1'b0, 1'b1, 3'd6);
    check("R6", 3'd6);
    apply(1'b0, 1'b0, 1'b0, 3'd0);
    check("R3", 3'd6);
    apply(1'b0, 1'b1, 1'b0, 3'd0);
    check("R4", 3'd0);
    apply(1'b0, 1'b1, 1'b0, 3'd0);
    check("R4", 3'd3);

    apply(1'b0, 1'b1, 1'b1, 3'd4);
    check("R6", 3'd4);
    apply(1'b0, 1'b1, 1'b0, 3'd0);
    check("R1", 3'd7);
    apply(1'b0, 1'b1, 1'b0, 3'd0);
    check("R2", 3'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: count=%0d expected=completion", count);
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule